// File: doc/BRIEF.md
# Iterative Integer Square Root Engine

This block computes the floor of the square root of an unsigned radicand. A radicand enters over a valid/ready handshake. The engine then works through the digit-by-digit method, resolving two radicand bits per clock. A one-hot power-of-four marker drives the method. The marker is seeded at the largest power of four that does not exceed the radicand, so small inputs finish in few cycles and large inputs take longer. The root leaves over a second valid/ready handshake.

The engine holds one operation at a time. The input side shows `in_ready` high only when the engine is idle. A source may hold `in_valid` and `in_data` for as long as it likes; the value is taken on the first edge where both valid and ready are high. On the output side, `out_valid` stays high and `out_root` stays fixed until the sink raises `out_ready`. When the sink keeps `out_ready` high, each result appears as a single-cycle pulse. No new radicand is accepted until the current result has been taken.

Top module: `isqrt_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A radicand is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the result has been taken.
- R3: For every 32-bit unsigned radicand x, `out_root` equals floor(sqrt(x)). This means root*root <= x and (root+1)*(root+1) > x.
- R4: A radicand of zero gives `out_root` = 0. Counting the accepting edge as edge 1, `out_valid` is first seen high after 1 edge.
- R5: For a nonzero radicand whose largest power of four not above it is 4^k (k from 0 to 15), `out_valid` is first seen high after k+2 edges, counting the accepting edge as edge 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_root` does not change. After an edge where both are 1, `out_valid` is 0 and `in_ready` is 1.
- R7: `in_valid` and `in_data` are ignored while the engine is busy or holding a result. The returned root belongs to the accepted radicand, and no extra result follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Radicand offered |
| in_ready | output | 1 | Engine idle and able to take a radicand |
| in_data | input | RAD_W (32) | Unsigned radicand |
| out_valid | output | 1 | Root available |
| out_ready | input | 1 | Sink takes the root |
| out_root | output | RAD_W/2 (16) | Floor of the square root |

## Verification
An exhaustive sweep of every radicand from 0 to 4095 covers each seed position in the low range, along with every root transition there. Values of the form n*n-1, n*n and n*n+2n, taken across the whole 16-bit root range, separate a correct floor from an off-by-one at each perfect-square boundary. These patterns also cover the largest seeds and the slowest latencies. Random 32-bit radicands exercise arbitrary bit mixes in the subtraction path. Latency is checked on every operation against the value predicted from the radicand's magnitude. Separate directed cases stall the output and present new data while busy, to show that held results stay put and that stray inputs are dropped.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HOLD = 2'd2
  } sq_state_e;

endpackage

// File: rtl/isqrt_seed.sv
// Finds the largest power of four not above the operand, as a one-hot vector.
module isqrt_seed #(
  parameter int W = 32
) (
  input  logic [W-1:0] operand,
  output logic [W-1:0] seed,
  output logic         seed_zero
);
  localparam int NPAIR = W / 2;

  logic [NPAIR-1:0] pair_hit;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_hit[p] = operand[2*p] | operand[2*p+1];
  end

  always_comb begin
    seed = '0;
    for (int j = 0; j < NPAIR; j++) begin
      if (pair_hit[j]) seed = W'(1) << (2 * j);
    end
  end

  assign seed_zero = ~|pair_hit;
endmodule

// File: rtl/isqrt_step.sv
// One digit-by-digit iteration: trial subtract, shift result, shift marker.
module isqrt_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_cur,
  input  logic [W-1:0] acc_cur,
  input  logic [W-1:0] mark_cur,
  output logic [W-1:0] rem_nxt,
  output logic [W-1:0] acc_nxt,
  output logic [W-1:0] mark_nxt,
  output logic         last
);
  logic [W:0] trial;
  logic       fits;

  always_comb begin
    trial    = {1'b0, acc_cur} + {1'b0, mark_cur};
    fits     = ({1'b0, rem_cur} >= trial);
    mark_nxt = mark_cur >> 2;
    if (fits) begin
      rem_nxt = rem_cur - trial[W-1:0];
      acc_nxt = (acc_cur >> 1) + mark_cur;
    end else begin
      rem_nxt = rem_cur;
      acc_nxt = acc_cur >> 1;
    end
    last = (mark_nxt == '0);
  end
endmodule

// File: rtl/isqrt_ctrl.sv
// Sequencer: idle, iterate, hold result until taken.
module isqrt_ctrl
  import isqrt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic seed_zero,
  input  logic step_last,
  output logic in_ready,
  output logic out_valid,
  output logic load_en,
  output logic step_en
);
  sq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (in_valid) st_d = seed_zero ? SQ_HOLD : SQ_RUN;
      SQ_RUN:  if (step_last) st_d = SQ_HOLD;
      SQ_HOLD: if (out_ready) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign in_ready  = (st_q == SQ_IDLE);
  assign out_valid = (st_q == SQ_HOLD);
  assign load_en   = (st_q == SQ_IDLE) && in_valid;
  assign step_en   = (st_q == SQ_RUN);
endmodule

// File: rtl/isqrt_engine.sv
module isqrt_engine #(
  parameter int RAD_W = 32,
  localparam int RES_W = RAD_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RAD_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_root
);
  logic [RAD_W-1:0] rem_q, acc_q, pow_q;
  logic [RAD_W-1:0] rem_n, acc_n, pow_n;
  logic [RAD_W-1:0] seed;
  logic             seed_zero, step_last, load_en, step_en;

  isqrt_seed #(.W(RAD_W)) u_seed (
    .operand   (in_data),
    .seed      (seed),
    .seed_zero (seed_zero)
  );

  isqrt_step #(.W(RAD_W)) u_step (
    .rem_cur  (rem_q),
    .acc_cur  (acc_q),
    .mark_cur (pow_q),
    .rem_nxt  (rem_n),
    .acc_nxt  (acc_n),
    .mark_nxt (pow_n),
    .last     (step_last)
  );

  isqrt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .seed_zero (seed_zero),
    .step_last (step_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load_en   (load_en),
    .step_en   (step_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      pow_q <= '0;
    end else if (load_en) begin
      rem_q <= in_data;
      acc_q <= '0;
      pow_q <= seed;
    end else if (step_en) begin
      rem_q <= rem_n;
      acc_q <= acc_n;
      pow_q <= pow_n;
    end
  end

  assign out_root = acc_q[RES_W-1:0];
endmodule

// File: rtl/isqrt_engine_chk.sv
module isqrt_engine_chk #(
  parameter int RAD_W = 32,
  localparam int RES_W = RAD_W / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [RAD_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_root,
  input logic [RAD_W-1:0] pow_q
);
  localparam int SQ_W = RAD_W + 2;

  logic [RAD_W-1:0] held_x;
  logic [SQ_W-1:0]  sq_lo, sq_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_x <= '0;
    else if (in_valid && in_ready) held_x <= in_data;
  end

  always_comb begin
    sq_lo = SQ_W'(out_root) * SQ_W'(out_root);
    sq_hi = (SQ_W'(out_root) + SQ_W'(1)) * (SQ_W'(out_root) + SQ_W'(1));
  end

  // R2
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  busy_while_holding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R3
  root_is_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sq_lo <= SQ_W'(held_x)) && (sq_hi > SQ_W'(held_x)));

  // R5
  marker_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pow_q));

  // R6
  result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_root)));

  // R6
  result_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind isqrt_engine isqrt_engine_chk #(.RAD_W(RAD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_root  (out_root),
  .pow_q     (pow_q)
);

// File: tb/isqrt_engine_test.sv
`timescale 1ns/1ps
module isqrt_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_root;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  isqrt_engine uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_root(out_root)
  );

  function automatic longint ref_root(input longint x);
    longint lo = 0, hi = 65535;
    while (lo < hi) begin
      longint mid = (lo + hi + 1) / 2;
      if (mid * mid <= x) lo = mid;
      else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic int ref_latency(input longint x);
    int k = 0;
    if (x == 0) return 1;
    while (k < 15 && (longint'(1) << (2 * (k + 1))) <= x) k++;
    return k + 2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Accepts x, waits for the result, checks root and latency, leaves idle.
  task automatic run_one(input logic [31:0] x, input bit stall);
    int edges = 1;
    longint xe = longint'(x);
    @(negedge clk);
    in_data   = x;
    in_valid  = 1'b1;
    out_ready = !stall;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && edges < 40) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    if (x == 0) begin
      check(out_root == 16'd0, "R4", "zero root", out_root, 0);
      check(edges == 1, "R4", "zero latency", edges, 1);
    end else begin
      check(longint'(out_root) == ref_root(xe), "R3", "root", out_root, ref_root(xe));
      check(edges == ref_latency(xe), "R5", "latency", edges, ref_latency(xe));
    end
    if (stall) begin
      for (int i = 0; i < 5; i++) begin
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R6", "held valid", out_valid, 1);
        check(longint'(out_root) == ref_root(xe), "R6", "held root", out_root, ref_root(xe));
      end
      out_ready = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R6", "valid after take", out_valid, 0);
    check(in_ready == 1'b1, "R6", "ready after take", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R2: accept then busy
    @(negedge clk);
    in_data  = 32'd50000;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2", "busy after accept", in_ready, 0);
    while (!out_valid) @(negedge clk);
    check(in_ready == 1'b0, "R2", "busy while holding", in_ready, 0);
    check(out_root == 16'd223, "R3", "root of 50000", out_root, 223);
    @(posedge clk);
    @(negedge clk);

    // Corners
    run_one(32'd0, 1'b0);
    run_one(32'd1, 1'b0);
    run_one(32'd2, 1'b0);
    run_one(32'd3, 1'b0);
    run_one(32'd4, 1'b0);
    run_one(32'hFFFF_FFFF, 1'b0);
    run_one(32'hFFFE_0001, 1'b0);
    run_one(32'hFFFE_0000, 1'b0);
    run_one(32'h4000_0000, 1'b0);
    run_one(32'h3FFF_FFFF, 1'b0);

    // R6: stalled output
    run_one(32'hFFFF_FFFF, 1'b1);
    run_one(32'd0, 1'b1);

    // R7: traffic while busy is ignored
    @(negedge clk);
    in_data  = 32'd1000000;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_data = 32'd7;
    while (!out_valid) begin
      check(in_ready == 1'b0, "R7", "not ready while busy", in_ready, 1'b0);
      @(negedge clk);
    end
    check(out_root == 16'd1000, "R7", "root of accepted value", out_root, 1000);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "no extra result", out_valid, 0);
    end

    // Exhaustive low range
    for (int v = 0; v < 4096; v++) run_one(32'(v), 1'b0);

    // Perfect-square boundaries across the root range
    for (int n = 1; n < 65536; n += 257) begin
      longint nn = longint'(n) * longint'(n);
      run_one(32'(nn - 1), 1'b0);
      run_one(32'(nn), 1'b0);
      run_one(32'(nn + 2 * n), 1'b0);
    end

    // Random radicands
    for (int i = 0; i < 400; i++) run_one($urandom(), 1'b0);

    summary();
    $finish;
  end
endmodule